// File: doc/BRIEF.md
# FIFO Pointer Set with Mark and Rewind

This block holds the addressing state of one FIFO channel whose storage is a plain RAM held elsewhere. It keeps a read address pointer, a write address pointer and a spare temporary pointer. A configuration bit attaches the temporary pointer to either the read side or the write side. A write to a 4-bit command field can save the attached live pointer into the temporary pointer (mark). It can also copy the temporary pointer back into the live pointer (reload), which lets software re-read a span of data or discard a partly written block. The same field can return every pointer to the empty state or wipe the recorded full and empty status.

Each pointer carries one wrap bit above its address bits, so equal addresses with different wrap bits mean full and equal pointers mean empty. Hardware events raise six sticky interrupt flags, which software clears by writing ones. Groups of these flags are folded into this set's bit of two shared summary words, one bit per pointer set.

Top module: `fifo_ptr_set`

## Requirements
- R1: After the synchronous reset the read, write and temporary pointers are 0, the empty output is 1, the full output is 0, all interrupt flags are 0 and the temporary pointer is attached to the read side.
- R2: A cycle with `bind_we` high stores `bind_val` as the attachment: 0 attaches the temporary pointer to the read pointer and 1 attaches it to the write pointer. A command written in that same cycle still uses the previous attachment.
- R3: A command write with bit 2 (mark) set copies the attached live pointer into the temporary pointer on the next clock.
- R4: A command write with bit 3 (reload) set copies the temporary pointer into the attached live pointer on the next clock. When mark and reload are set together, the two values are exchanged.
- R5: A command write with bit 1 (pointer reset) set clears all three pointers, drives empty to 1 and full to 0 on the next clock, and overrides every other command bit in that write, including status clear.
- R6: A command write with bit 0 (status clear) and without bit 1 drives both the full and the empty output to 0 on the next clock. They stay 0 until a read or write pointer changes.
- R7: A `fifo_wr` strobe advances the write pointer by one and a `fifo_rd` strobe advances the read pointer by one, both modulo twice the RAM depth. A write while the pointers show full and a read while they show empty leave that pointer unchanged.
- R8: When mark, reload or pointer reset is written in the same cycle as a read or write strobe, the strobe's increment is dropped.
- R9: Whenever a read or write pointer changes, full and empty are recomputed from the new pointers in the same clock. Empty means equal pointers. Full means equal address bits with different wrap bits. Full and empty are never both 1.
- R10: Interrupt flags are set by events: bit 5 when the pointers become full, bit 4 when they become empty, bit 3 when a read step lands on the temporary pointer's address, bit 2 when a write step does so, bit 1 on a write strobe while full, and bit 0 on a read strobe while empty. Bits 1 and 0 are not raised in a cycle that also carries mark, reload or pointer reset.
- R11: A cycle with `irq_clr_we` high clears every flag whose `irq_clr_mask` bit is 1. A flag that is set by an event in the same cycle stays 1, and flags stay set until they are cleared.
- R12: Bit `SET_IDX` of `sum_a` is 1 exactly when any of flags 5 to 2 is 1, and bit `SET_IDX` of `sum_b` is 1 exactly when flag 1 or flag 0 is 1. All other bits of both words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bind_we | input | 1 | Attachment write strobe |
| bind_val | input | 1 | Attachment value, 0 read side, 1 write side |
| cmd_we | input | 1 | Command field write strobe |
| cmd_bits | input | 4 | Bit 3 reload, bit 2 mark, bit 1 pointer reset, bit 0 status clear |
| fifo_rd | input | 1 | One-word read strobe |
| fifo_wr | input | 1 | One-word write strobe |
| irq_clr_we | input | 1 | Flag clear strobe |
| irq_clr_mask | input | 6 | Flags to clear, one bit each |
| rd_addr | output | ADDR_W | Read address into the RAM |
| wr_addr | output | ADDR_W | Write address into the RAM |
| tmp_addr | output | ADDR_W | Temporary pointer address |
| full | output | 1 | Recorded full status |
| empty | output | 1 | Recorded empty status |
| irq_flags | output | 6 | Sticky interrupt flags |
| sum_a | output | NUM_SETS | Summary word A, this set's bit only |
| sum_b | output | NUM_SETS | Summary word B, this set's bit only |

## Verification
On every cycle the assertions check that full and empty are never both 1. They also check that pointer reset and status clear land on the next clock, that a mark leaves the live pointers alone, that no pointer moves past full or empty, and that flags only drop when cleared. The exchange on a combined mark and reload, the rollback of a write span, and each flag's event timing need the bench's scenarios and its cycle-accurate model. The same holds for the rule that a command sees the attachment from before its own cycle.

// File: rtl/fps_pkg.sv
package fps_pkg;

    localparam int CMD_W  = 4;
    localparam int FLAG_N = 6;

    localparam int FL_FULL  = 5;
    localparam int FL_EMPTY = 4;
    localparam int FL_RDHIT = 3;
    localparam int FL_WRHIT = 2;
    localparam int FL_OVR   = 1;
    localparam int FL_UND   = 0;

    typedef enum logic {
        BIND_RD = 1'b0,
        BIND_WR = 1'b1
    } bind_e;

    typedef struct packed {
        logic reload;
        logic mark;
        logic preset;
        logic sclr;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic we, input logic [CMD_W-1:0] bits);
        cmd_t c;
        c = we ? cmd_t'(bits) : '0;
        if (c.preset) begin
            c.sclr   = 1'b0;
            c.mark   = 1'b0;
            c.reload = 1'b0;
        end
        return c;
    endfunction

    function automatic logic cmd_holds(input cmd_t c);
        return c.mark | c.reload | c.preset;
    endfunction

endpackage

// File: rtl/fps_ptr_core.sv
module fps_ptr_core
    import fps_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    input  bind_e             bind_sel,
    input  logic              fifo_rd,
    input  logic              fifo_wr,
    output logic [ADDR_W:0]   rd_ptr,
    output logic [ADDR_W:0]   wr_ptr,
    output logic [ADDR_W:0]   tmp_ptr,
    output logic [ADDR_W:0]   rd_nxt,
    output logic [ADDR_W:0]   wr_nxt,
    output logic              cur_full,
    output logic              cur_empty,
    output logic              nxt_full,
    output logic              nxt_empty,
    output logic              rd_step,
    output logic              wr_step,
    output logic              moved
);

    localparam int PW = ADDR_W + 1;

    typedef struct packed {
        logic [PW-1:0] rd;
        logic [PW-1:0] wr;
        logic [PW-1:0] tmp;
    } ptrs_t;

    ptrs_t cur, nxt;
    logic  hold;

    function automatic logic is_full(input logic [PW-1:0] r, input logic [PW-1:0] w);
        return (r[ADDR_W] != w[ADDR_W]) && (r[ADDR_W-1:0] == w[ADDR_W-1:0]);
    endfunction

    assign hold      = cmd_holds(cmd);
    assign cur_empty = (cur.rd == cur.wr);
    assign cur_full  = is_full(cur.rd, cur.wr);
    assign rd_step   = fifo_rd && !cur_empty && !hold;
    assign wr_step   = fifo_wr && !cur_full && !hold;

    always_comb begin
        nxt = cur;
        if (cmd.preset) begin
            nxt = '0;
        end else if (cmd.mark || cmd.reload) begin
            if (bind_sel == BIND_RD) begin
                if (cmd.mark)   nxt.tmp = cur.rd;
                if (cmd.reload) nxt.rd  = cur.tmp;
            end else begin
                if (cmd.mark)   nxt.tmp = cur.wr;
                if (cmd.reload) nxt.wr  = cur.tmp;
            end
        end else begin
            if (rd_step) nxt.rd = cur.rd + PW'(1);
            if (wr_step) nxt.wr = cur.wr + PW'(1);
        end
    end

    assign nxt_empty = (nxt.rd == nxt.wr);
    assign nxt_full  = is_full(nxt.rd, nxt.wr);
    assign moved     = !cmd.preset && (cmd.reload || rd_step || wr_step);

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign rd_ptr  = cur.rd;
    assign wr_ptr  = cur.wr;
    assign tmp_ptr = cur.tmp;
    assign rd_nxt  = nxt.rd;
    assign wr_nxt  = nxt.wr;

endmodule

// File: rtl/fps_status.sv
module fps_status
    import fps_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_t cmd,
    input  logic moved,
    input  logic nxt_full,
    input  logic nxt_empty,
    output logic full,
    output logic empty
);

    always_ff @(posedge clk) begin
        if (rst || cmd.preset) begin
            full  <= 1'b0;
            empty <= 1'b1;
        end else if (cmd.sclr) begin
            full  <= 1'b0;
            empty <= 1'b0;
        end else if (moved) begin
            full  <= nxt_full;
            empty <= nxt_empty;
        end
    end

endmodule

// File: rtl/fps_irq.sv
module fps_irq
    import fps_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_SETS = 4,
    parameter int SET_IDX  = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              fifo_rd,
    input  logic              fifo_wr,
    input  logic              cur_full,
    input  logic              cur_empty,
    input  logic              nxt_full,
    input  logic              nxt_empty,
    input  logic              rd_step,
    input  logic              wr_step,
    input  logic [ADDR_W:0]   rd_nxt,
    input  logic [ADDR_W:0]   wr_nxt,
    input  logic [ADDR_W:0]   tmp_ptr,
    input  logic              clr_we,
    input  logic [FLAG_N-1:0] clr_mask,
    output logic [FLAG_N-1:0] flags,
    output logic [NUM_SETS-1:0] sum_a,
    output logic [NUM_SETS-1:0] sum_b
);

    logic [FLAG_N-1:0] ev, clr;
    logic              grp_a, grp_b;

    always_comb begin
        ev           = '0;
        ev[FL_FULL]  = nxt_full && !cur_full;
        ev[FL_EMPTY] = nxt_empty && !cur_empty;
        ev[FL_RDHIT] = rd_step && (rd_nxt[ADDR_W-1:0] == tmp_ptr[ADDR_W-1:0]);
        ev[FL_WRHIT] = wr_step && (wr_nxt[ADDR_W-1:0] == tmp_ptr[ADDR_W-1:0]);
        ev[FL_OVR]   = fifo_wr && cur_full && !hold;
        ev[FL_UND]   = fifo_rd && cur_empty && !hold;
    end

    assign clr = clr_we ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr) | ev;
    end

    assign grp_a = |flags[FL_FULL:FL_WRHIT];
    assign grp_b = |flags[FL_OVR:FL_UND];

    for (genvar g = 0; g < NUM_SETS; g++) begin : g_sum
        if (g == SET_IDX) begin : g_own
            assign sum_a[g] = grp_a;
            assign sum_b[g] = grp_b;
        end else begin : g_other
            assign sum_a[g] = 1'b0;
            assign sum_b[g] = 1'b0;
        end
    end

endmodule

// File: rtl/fifo_ptr_set.sv
module fifo_ptr_set
    import fps_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_SETS = 4,
    parameter int SET_IDX  = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bind_we,
    input  logic                bind_val,
    input  logic                cmd_we,
    input  logic [3:0]          cmd_bits,
    input  logic                fifo_rd,
    input  logic                fifo_wr,
    input  logic                irq_clr_we,
    input  logic [5:0]          irq_clr_mask,
    output logic [ADDR_W-1:0]   rd_addr,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [ADDR_W-1:0]   tmp_addr,
    output logic                full,
    output logic                empty,
    output logic [5:0]          irq_flags,
    output logic [NUM_SETS-1:0] sum_a,
    output logic [NUM_SETS-1:0] sum_b
);

    cmd_t            cmd;
    bind_e           bind_q;
    logic [ADDR_W:0] rd_ptr, wr_ptr, tmp_ptr, rd_nxt, wr_nxt;
    logic            cur_full, cur_empty, nxt_full, nxt_empty;
    logic            rd_step, wr_step, moved;

    assign cmd = decode_cmd(cmd_we, cmd_bits);

    always_ff @(posedge clk) begin
        if (rst)          bind_q <= BIND_RD;
        else if (bind_we) bind_q <= bind_e'(bind_val);
    end

    fps_ptr_core #(.ADDR_W(ADDR_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .bind_sel  (bind_q),
        .fifo_rd   (fifo_rd),
        .fifo_wr   (fifo_wr),
        .rd_ptr    (rd_ptr),
        .wr_ptr    (wr_ptr),
        .tmp_ptr   (tmp_ptr),
        .rd_nxt    (rd_nxt),
        .wr_nxt    (wr_nxt),
        .cur_full  (cur_full),
        .cur_empty (cur_empty),
        .nxt_full  (nxt_full),
        .nxt_empty (nxt_empty),
        .rd_step   (rd_step),
        .wr_step   (wr_step),
        .moved     (moved)
    );

    fps_status u_status (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .moved     (moved),
        .nxt_full  (nxt_full),
        .nxt_empty (nxt_empty),
        .full      (full),
        .empty     (empty)
    );

    fps_irq #(.ADDR_W(ADDR_W), .NUM_SETS(NUM_SETS), .SET_IDX(SET_IDX)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .hold      (cmd_holds(cmd)),
        .fifo_rd   (fifo_rd),
        .fifo_wr   (fifo_wr),
        .cur_full  (cur_full),
        .cur_empty (cur_empty),
        .nxt_full  (nxt_full),
        .nxt_empty (nxt_empty),
        .rd_step   (rd_step),
        .wr_step   (wr_step),
        .rd_nxt    (rd_nxt),
        .wr_nxt    (wr_nxt),
        .tmp_ptr   (tmp_ptr),
        .clr_we    (irq_clr_we),
        .clr_mask  (irq_clr_mask),
        .flags     (irq_flags),
        .sum_a     (sum_a),
        .sum_b     (sum_b)
    );

    assign rd_addr  = rd_ptr[ADDR_W-1:0];
    assign wr_addr  = wr_ptr[ADDR_W-1:0];
    assign tmp_addr = tmp_ptr[ADDR_W-1:0];

endmodule

// File: rtl/fifo_ptr_set_chk.sv
module fifo_ptr_set_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_we,
    input logic [3:0]        cmd_bits,
    input logic              fifo_rd,
    input logic              fifo_wr,
    input logic              irq_clr_we,
    input logic [5:0]        irq_clr_mask,
    input logic              bind_q,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W-1:0] tmp_addr,
    input logic              full,
    input logic              empty,
    input logic [5:0]        irq_flags
);

    logic       any_hold;
    logic [5:0] keep;

    assign any_hold = cmd_we && (|cmd_bits[3:1]);
    assign keep     = irq_flags & ~(irq_clr_we ? irq_clr_mask : 6'b0);

    // R5
    preset_zero_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_we && cmd_bits[1] |=> rd_addr == '0 && wr_addr == '0 && tmp_addr == '0 && empty && !full);

    // R6
    status_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_we && cmd_bits[0] && !cmd_bits[1] |=> !full && !empty);

    // R3
    mark_read_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_we && cmd_bits[2] && !cmd_bits[3] && !cmd_bits[1] && !bind_q |=> tmp_addr == $past(rd_addr));

    // R8
    mark_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_we && cmd_bits[2] && !cmd_bits[3] && !cmd_bits[1] |=> $stable(rd_addr) && $stable(wr_addr));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        full && fifo_wr && !any_hold |=> $stable(wr_addr));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        empty && fifo_rd && !any_hold |=> $stable(rd_addr));

    // R9
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    // R11
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        keep != 6'b0 |=> (irq_flags & $past(keep)) == $past(keep));

endmodule

bind fifo_ptr_set fifo_ptr_set_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_we       (cmd_we),
    .cmd_bits     (cmd_bits),
    .fifo_rd      (fifo_rd),
    .fifo_wr      (fifo_wr),
    .irq_clr_we   (irq_clr_we),
    .irq_clr_mask (irq_clr_mask),
    .bind_q       (bind_q),
    .rd_addr      (rd_addr),
    .wr_addr      (wr_addr),
    .tmp_addr     (tmp_addr),
    .full         (full),
    .empty        (empty),
    .irq_flags    (irq_flags)
);

// File: tb/test_fifo_ptr_set.sv
module test_fifo_ptr_set;

    localparam int CLK_PERIOD = 10;
    localparam int AW   = 8;
    localparam int NS   = 4;
    localparam int PMOD = 2 << AW;
    localparam int AMSK = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bind_we = 0, bind_val = 0, cmd_we = 0, fifo_rd = 0, fifo_wr = 0, irq_clr_we = 0;
    logic [3:0]    cmd_bits = '0;
    logic [5:0]    irq_clr_mask = '0;
    logic [AW-1:0] rd_addr, wr_addr, tmp_addr;
    logic          full, empty;
    logic [5:0]    irq_flags;
    logic [NS-1:0] sum_a, sum_b;

    int vectors = 0;
    int errors  = 0;

    int m_rd = 0, m_wr = 0, m_tmp = 0, m_bind = 0, m_full = 0, m_empty = 1;
    logic [5:0] m_fl = '0;

    fifo_ptr_set i_fifo_ptr_set (
        .clk(clk), .rst(rst), .bind_we(bind_we), .bind_val(bind_val),
        .cmd_we(cmd_we), .cmd_bits(cmd_bits), .fifo_rd(fifo_rd), .fifo_wr(fifo_wr),
        .irq_clr_we(irq_clr_we), .irq_clr_mask(irq_clr_mask),
        .rd_addr(rd_addr), .wr_addr(wr_addr), .tmp_addr(tmp_addr),
        .full(full), .empty(empty), .irq_flags(irq_flags), .sum_a(sum_a), .sum_b(sum_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [NS-1:0] ea, eb;
        ea = '0; eb = '0;
        ea[0] = |m_fl[5:2];
        eb[0] = |m_fl[1:0];
        chk("R7 rd_addr",  rd_addr,  m_rd & AMSK);
        chk("R7 wr_addr",  wr_addr,  m_wr & AMSK);
        chk("R3 tmp_addr", tmp_addr, m_tmp & AMSK);
        chk("R9 full",     full,     m_full);
        chk("R9 empty",    empty,    m_empty);
        chk("R10 flags",   irq_flags, m_fl);
        chk("R12 sum_a",   sum_a,    ea);
        chk("R12 sum_b",   sum_b,    eb);
    endtask

    task automatic cyc(input logic rd, input logic wr, input logic cwe, input logic [3:0] cb,
                       input logic bwe, input logic bv, input logic iwe, input logic [5:0] im);
        int  nrd, nwr, ntmp;
        bit  pre, clr, mk, rl, hold, cf, ce, nf, ne, rs, ws, mv;
        logic [5:0] ev;
        fifo_rd = rd; fifo_wr = wr; cmd_we = cwe; cmd_bits = cb;
        bind_we = bwe; bind_val = bv; irq_clr_we = iwe; irq_clr_mask = im;
        pre  = cwe && cb[1];
        clr  = cwe && cb[0] && !pre;
        mk   = cwe && cb[2] && !pre;
        rl   = cwe && cb[3] && !pre;
        hold = pre || mk || rl;
        ce = (m_rd == m_wr);
        cf = (((m_wr - m_rd + PMOD) % PMOD) == (PMOD / 2));
        rs = rd && !ce && !hold;
        ws = wr && !cf && !hold;
        nrd = m_rd; nwr = m_wr; ntmp = m_tmp;
        if (pre) begin
            nrd = 0; nwr = 0; ntmp = 0;
        end else if (mk || rl) begin
            if (m_bind == 0) begin
                if (mk) ntmp = m_rd;
                if (rl) nrd = m_tmp;
            end else begin
                if (mk) ntmp = m_wr;
                if (rl) nwr = m_tmp;
            end
        end else begin
            if (rs) nrd = (m_rd + 1) % PMOD;
            if (ws) nwr = (m_wr + 1) % PMOD;
        end
        ne = (nrd == nwr);
        nf = (((nwr - nrd + PMOD) % PMOD) == (PMOD / 2));
        mv = !pre && (rl || rs || ws);
        ev = '0;
        ev[5] = nf && !cf;
        ev[4] = ne && !ce;
        ev[3] = rs && ((nrd & AMSK) == (m_tmp & AMSK));
        ev[2] = ws && ((nwr & AMSK) == (m_tmp & AMSK));
        ev[1] = wr && cf && !hold;
        ev[0] = rd && ce && !hold;
        m_fl = (m_fl & ~(iwe ? im : 6'b0)) | ev;
        if (pre) begin
            m_full = 0; m_empty = 1;
        end else if (clr) begin
            m_full = 0; m_empty = 0;
        end else if (mv) begin
            m_full = nf; m_empty = ne;
        end
        m_rd = nrd; m_wr = nwr; m_tmp = ntmp;
        if (bwe) m_bind = bv;
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(); cyc(0,0,0,4'h0,0,0,0,6'h0); endtask
    task automatic wr1();  cyc(0,1,0,4'h0,0,0,0,6'h0); endtask
    task automatic rd1();  cyc(1,0,0,4'h0,0,0,0,6'h0); endtask
    task automatic cmd(input logic [3:0] c); cyc(0,0,1,c,0,0,0,6'h0); endtask
    task automatic setbind(input logic v); cyc(0,0,0,4'h0,1,v,0,6'h0); endtask
    task automatic clrf(input logic [5:0] m); cyc(0,0,0,4'h0,0,0,1,m); endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL R1 watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 rd_addr", rd_addr, 0);
        chk("R1 empty", empty, 1);
        chk("R1 full", full, 0);
        chk("R1 flags", irq_flags, 0);
        compare_all();

        repeat (10) wr1();
        chk("R7 wr after 10 writes", wr_addr, 10);
        chk("R9 not empty", empty, 0);
        repeat (3) rd1();
        cmd(4'b0100);
        chk("R3 mark on read side", tmp_addr, 3);
        repeat (4) rd1();
        cmd(4'b1000);
        chk("R4 reload rewinds read", rd_addr, 3);

        // R2: attach to write side; a mark in the same cycle uses the old binding
        cyc(0,0,1,4'b0100,1,1,0,6'h0);
        chk("R2 same-cycle mark uses read side", tmp_addr, 3);
        cmd(4'b0100);
        chk("R2 mark on write side", tmp_addr, 10);
        repeat (5) wr1();
        cmd(4'b1000);
        chk("R4 reload rolls back write", wr_addr, 10);
        cyc(1,1,1,4'b0100,0,0,0,6'h0);
        chk("R8 read dropped", rd_addr, 3);
        chk("R8 write dropped", wr_addr, 10);

        repeat (7) rd1();
        chk("R10 read hit flag", irq_flags[3], 1);
        chk("R10 empty flag", irq_flags[4], 1);
        rd1();
        chk("R10 underrun flag", irq_flags[0], 1);
        chk("R7 no read past empty", rd_addr, 10);
        chk("R12 sum_b own bit", sum_b, 4'b0001);
        chk("R12 sum_a own bit", sum_a, 4'b0001);
        clrf(6'h3F);
        chk("R11 flags cleared", irq_flags, 0);
        cyc(1,0,0,4'h0,0,0,1,6'h01);
        chk("R11 set beats clear", irq_flags[0], 1);
        cmd(4'b0001);
        chk("R6 clear drops empty", empty, 0);
        idle();
        chk("R6 stays clear", empty, 0);
        wr1();
        cmd(4'b0011);
        chk("R5 reset wins over clear", empty, 1);
        chk("R5 wr zero", wr_addr, 0);

        repeat (256) wr1();
        chk("R9 full after depth writes", full, 1);
        chk("R10 full flag", irq_flags[5], 1);
        wr1();
        chk("R7 no write past full", wr_addr, 0);
        chk("R10 overrun flag", irq_flags[1], 1);
        repeat (5) rd1();
        setbind(0);
        cmd(4'b0100);
        repeat (2) rd1();
        cmd(4'b1100);
        chk("R4 exchange live", rd_addr, 5);
        chk("R4 exchange tmp", tmp_addr, 7);

        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom;
            cyc(r[0], r[1] | r[2],
                (r[7:4] == 0), r[11:8],
                (r[15:12] == 0), r[16],
                (r[19:17] == 0), r[25:20]);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule